// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is one 8-bit input channel with a two-wire handshake. A peripheral puts a byte on the port pins and pulses an active-low strobe. The block stores the byte in an input latch, raises a buffer-full flag back to the peripheral, and, when the host has enabled interrupts, raises an interrupt request. The host reads the latch with its chip select and read strobe. The interrupt request drops when that read begins, and the buffer-full flag drops when the read ends. The host sets or clears the interrupt enable with a single-bit set/reset command word.

The peripheral strobe, the chip select and the read strobe are all asynchronous. Each passes through a two-flop synchronizer before its edges are detected. The pin data passes through a synchronizer of the same depth, so the byte that is captured is the one sampled together with the first low strobe sample. A four-state machine tracks the handshake:

- EMPTY: nothing is held.
- STROBE: the peripheral strobe is low.
- FULL: a byte is held and waiting for the host.
- READ: a host read is in progress.

The transitions are:

- EMPTY→STROBE on a strobe fall.
- STROBE→FULL on a strobe rise.
- FULL→READ on a read fall.
- FULL→STROBE on a strobe fall, which is an overrun.
- READ→EMPTY on a read rise.
- READ→STROBE on a strobe fall. A strobe fall takes priority over a read rise.

Top module: `strobed_in_port`

## Requirements
- R1: After reset `ibf` and `intr` are low, the interrupt enable is clear and the latch holds zero.
- R2: The byte on `pin_d` at the strobe's falling edge is captured into the latch. Later changes on `pin_d` do not alter the latch.
- R3: `ibf` rises while `stb_n` is still low and stays high after `stb_n` returns high, until the host reads.
- R4: `ibf` clears on the rising edge of the host read (`rd_n` returning high with `cs_n` low), not at its start.
- R5: `intr` is high only when the strobe has returned high, `ibf` is high and the enable is set. It stays low while `stb_n` is low.
- R6: `intr` clears on the falling edge of the host read.
- R7: A command write with `cmd_d[7]`=0 and `cmd_d[3:1]` equal to the enable bit index (default 4) sets the enable when `cmd_d[0]`=1 and clears it when `cmd_d[0]`=0. Clearing it drops a pending `intr`.
- R8: A command with `cmd_d[7]`=1, or with a different bit index, leaves the enable unchanged.
- R9: `rd_n` low while `cs_n` is high is not a read. `ibf` and `intr` are unaffected and `host_q` stays zero.
- R10: A strobe that arrives while a byte is held overwrites the latch, and `ibf` stays high.
- R11: `host_q` shows the latch only while `cs_n` and `rd_n` are both low. Otherwise it is zero.
- R12: A host read while the buffer is empty leaves `ibf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| pin_d | input | 8 | Peripheral data pins |
| ibf | output | 1 | Input buffer full, to the peripheral |
| intr | output | 1 | Interrupt request to the host |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| host_q | output | 8 | Read data, the latch while a read is active, else zero |
| cmd_wr | input | 1 | One-cycle command write strobe, synchronous |
| cmd_d | input | 8 | Command word |

## Verification
The bench holds a read low for many cycles. A design that clears `ibf` at the start of a read fails that check, and so does one that keeps `intr` until the read ends. It enables interrupts before the strobe and holds the strobe low, which catches a request raised at the strobe's falling edge instead of its release. It changes the pins after capture and strobes twice without a read, so a latch that follows the pins live or refuses to overwrite shows the wrong byte. It also sends mode words, wrong bit indices and reads without chip select. A decoder that ignores bit 7 or the index, or a read path that ignores `cs_n`, would then change the enable or the flags.

// File: rtl/sip_pkg.sv
package sip_pkg;
    typedef enum logic [1:0] {
        HS_EMPTY  = 2'd0,
        HS_STROBE = 2'd1,
        HS_FULL   = 2'd2,
        HS_READ   = 2'd3
    } hs_state_t;

    localparam int CMD_MODE_BIT = 7;
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sip_ien.sv
module sip_ien #(
    parameter int DW      = 8,
    parameter int IEN_BIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_d,
    output logic          ien_nx,
    output logic          ien_q
);
    localparam logic [2:0] SEL = 3'(IEN_BIT);

    logic hit;

    assign hit    = cmd_wr && !cmd_d[sip_pkg::CMD_MODE_BIT] && (cmd_d[3:1] == SEL);
    assign ien_nx = hit ? cmd_d[0] : ien_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ien_q <= 1'b0;
        else        ien_q <= ien_nx;
    end
endmodule

// File: rtl/sip_latch.sv
module sip_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= d;
    end
endmodule

// File: rtl/sip_fsm.sv
module sip_fsm
    import sip_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb_fall,
    input  logic      stb_rise,
    input  logic      rd_fall,
    input  logic      rd_rise,
    input  logic      ien_nx,
    output hs_state_t state_q,
    output logic      ibf,
    output logic      intr
);
    hs_state_t state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            HS_EMPTY:  if (stb_fall) state_nx = HS_STROBE;
            HS_STROBE: if (stb_rise) state_nx = HS_FULL;
            HS_FULL: begin
                if (stb_fall)     state_nx = HS_STROBE;
                else if (rd_fall) state_nx = HS_READ;
            end
            HS_READ: begin
                if (stb_fall)     state_nx = HS_STROBE;
                else if (rd_rise) state_nx = HS_EMPTY;
            end
            default: state_nx = HS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_EMPTY;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf  <= 1'b0;
            intr <= 1'b0;
        end else begin
            ibf  <= (state_nx != HS_EMPTY);
            intr <= (state_nx == HS_FULL) && ien_nx;
        end
    end
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
    import sip_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int IEN_BIT     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_n,
    input  logic [DW-1:0] pin_d,
    output logic          ibf,
    output logic          intr,
    input  logic          cs_n,
    input  logic          rd_n,
    output logic [DW-1:0] host_q,
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_d
);
    logic          rd_act;
    logic [1:0]    ctl_s;
    logic          stb_s, rd_s, stb_prev, rd_prev;
    logic          stb_fall, stb_rise, rd_fall, rd_rise;
    logic [DW-1:0] d_sync, latch_q;
    logic          ien_nx, ien_q;
    hs_state_t     state_q;

    assign rd_act = !cs_n && !rd_n;

    sip_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({stb_n, rd_act}), .q(ctl_s)
    );

    sip_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_d), .q(d_sync)
    );

    assign stb_s = ctl_s[1];
    assign rd_s  = ctl_s[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_prev <= 1'b1;
            rd_prev  <= 1'b0;
        end else begin
            stb_prev <= stb_s;
            rd_prev  <= rd_s;
        end
    end

    assign stb_fall = stb_prev && !stb_s;
    assign stb_rise = !stb_prev && stb_s;
    assign rd_fall  = !rd_prev && rd_s;
    assign rd_rise  = rd_prev && !rd_s;

    sip_latch #(.DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .cap(stb_fall), .d(d_sync), .q(latch_q)
    );

    sip_ien #(.DW(DW), .IEN_BIT(IEN_BIT)) u_ien (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_d(cmd_d),
        .ien_nx(ien_nx), .ien_q(ien_q)
    );

    sip_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .stb_fall(stb_fall), .stb_rise(stb_rise),
        .rd_fall(rd_fall), .rd_rise(rd_rise),
        .ien_nx(ien_nx), .state_q(state_q),
        .ibf(ibf), .intr(intr)
    );

    assign host_q = rd_act ? latch_q : '0;
endmodule

// File: rtl/sip_chk.sv
module sip_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ibf,
    input logic          intr,
    input logic          ien_q,
    input logic          rd_rise,
    input logic          stb_fall,
    input logic          cmd_wr,
    input logic [DW-1:0] d_sync,
    input logic [DW-1:0] latch_q
);
    // R5
    intr_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ien_q);

    // R5
    intr_needs_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ibf);

    // R4
    ibf_fall_on_read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ibf) |-> $past(rd_rise));

    // R2
    capture_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fall |=> (latch_q == $past(d_sync)));

    // R8
    ien_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ien_q) |-> $past(cmd_wr));
endmodule

bind strobed_in_port sip_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ibf(ibf), .intr(intr), .ien_q(ien_q),
    .rd_rise(rd_rise), .stb_fall(stb_fall), .cmd_wr(cmd_wr),
    .d_sync(d_sync), .latch_q(latch_q)
);

// File: tb/tb_strobed_in_port.sv
module tb_strobed_in_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_n = 1'b1;
    logic [7:0] pin_d = 8'h00;
    logic       ibf, intr;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] host_q;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_d = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strobed_in_port dut (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .pin_d(pin_d),
        .ibf(ibf), .intr(intr), .cs_n(cs_n), .rd_n(rd_n),
        .host_q(host_q), .cmd_wr(cmd_wr), .cmd_d(cmd_d)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] w);
        @(negedge clk);
        cmd_d  = w;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        settle();
    endtask

    task automatic strobe(input logic [7:0] v);
        pin_d = v;
        settle();
        stb_n = 1'b0;
        settle();
        stb_n = 1'b1;
        settle();
    endtask

    task automatic host_read(input logic [7:0] exp, input string req);
        cs_n = 1'b0;
        rd_n = 1'b0;
        settle();
        chk(req, host_q, exp);
        rd_n = 1'b1;
        cs_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        chk("R1 ibf", {7'd0, ibf}, 8'd0);
        chk("R1 intr", {7'd0, intr}, 8'd0);
        cs_n = 1'b0; rd_n = 1'b0; settle();
        chk("R1 latch", host_q, 8'h00);
        rd_n = 1'b1; cs_n = 1'b1; settle();
        strobe(8'h11);
        chk("R1 enable clear, no intr", {7'd0, intr}, 8'd0);
        host_read(8'h11, "R2 read");
    endtask

    task automatic t_capture();
        cmd(8'h09);
        pin_d = 8'hA5; settle();
        stb_n = 1'b0; settle();
        chk("R3 ibf during strobe", {7'd0, ibf}, 8'd1);
        chk("R5 no intr while strobe low", {7'd0, intr}, 8'd0);
        pin_d = 8'h3C; settle();
        stb_n = 1'b1; settle();
        chk("R3 ibf held", {7'd0, ibf}, 8'd1);
        chk("R5 intr raised", {7'd0, intr}, 8'd1);
        pin_d = 8'hFF; settle();
        cs_n = 1'b0; rd_n = 1'b0; settle();
        chk("R2 latch not live", host_q, 8'hA5);
        chk("R6 intr cleared at read start", {7'd0, intr}, 8'd0);
        chk("R4 ibf still high mid-read", {7'd0, ibf}, 8'd1);
        rd_n = 1'b1; settle();
        chk("R11 host_q zero without rd", host_q, 8'h00);
        chk("R4 ibf cleared at read end", {7'd0, ibf}, 8'd0);
        cs_n = 1'b1; settle();
    endtask

    task automatic t_cmd();
        strobe(8'h5A);
        chk("R5 intr pending", {7'd0, intr}, 8'd1);
        cmd(8'h88);
        chk("R8 mode word ignored", {7'd0, intr}, 8'd1);
        cmd(8'h0C);
        chk("R8 other bit ignored", {7'd0, intr}, 8'd1);
        cmd(8'h08);
        chk("R7 clear drops intr", {7'd0, intr}, 8'd0);
        chk("R7 ibf unaffected", {7'd0, ibf}, 8'd1);
        cmd(8'h09);
        chk("R7 set restores intr", {7'd0, intr}, 8'd1);
        cmd(8'h89);
        cmd(8'h08);
        cmd(8'h8F);
        chk("R8 mode word keeps enable clear", {7'd0, intr}, 8'd0);
        cmd(8'h09);
    endtask

    task automatic t_nocs();
        rd_n = 1'b0; settle();
        chk("R9 host_q zero", host_q, 8'h00);
        chk("R9 intr kept", {7'd0, intr}, 8'd1);
        rd_n = 1'b1; settle();
        chk("R9 ibf kept", {7'd0, ibf}, 8'd1);
        host_read(8'h5A, "R11 read data");
        chk("R4 ibf cleared", {7'd0, ibf}, 8'd0);
    endtask

    task automatic t_overrun();
        strobe(8'h12);
        strobe(8'h34);
        chk("R10 ibf stays", {7'd0, ibf}, 8'd1);
        host_read(8'h34, "R10 newest byte");
        chk("R10 ibf cleared after read", {7'd0, ibf}, 8'd0);
    endtask

    task automatic t_empty_read();
        host_read(8'h34, "R12 latch kept");
        chk("R12 ibf stays low", {7'd0, ibf}, 8'd0);
        chk("R12 intr stays low", {7'd0, intr}, 8'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_capture();
        t_cmd();
        t_nocs();
        t_overrun();
        t_empty_read();
        done = 1;
        summary();
    end

    initial begin
        #1ms;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end
endmodule